// File: doc/BRIEF.md
# USB Host Controller Status and Interrupt Request Logic

This block keeps the status register and the interrupt enable register of a USB host controller and turns them into one level-sensitive interrupt request for the host. The transaction engine reports events as single-cycle pulses. These events are a finished transaction, an error on a transaction, a resume signal from a downstream device, and an internal processor error. With each event the engine also gives the descriptor attributes that go with it: the interrupt-on-complete flag, whether short-packet detection is enabled, the actual length and the maximum length. The global-suspend flag comes from the command register, and a run input comes from the command register's run/stop control.

Software reads and writes both registers through a plain one-cycle write strobe with a one-bit address: 0 selects status and 1 selects enable. Read data is combinational on the address. A status bit is cleared by writing a one to it. Each maskable status bit reaches the interrupt line only when its enable bit is set. A processor error always reaches it.

Top module: `uhc_irq_status`

## Requirements
- R1: After reset the status register reads 0x0020 and the enable register reads 0x0000, and `irq` is low.
- R2: Status bits 0 (transfer), 1 (error), 2 (resume) and 4 (processor error) are cleared only by a status write with a 1 in that position. A 0 in that position leaves the bit unchanged.
- R3: Status bit 2 is set by a `resume_sig` pulse only while `gsusp` is 1. At any other time the pulse changes nothing.
- R4: Status bit 0 is set in the cycle after a `txn_done` pulse with `txn_ioc` high. It is also set after a `txn_done` pulse with `txn_spd_en` high and `txn_act_len` strictly less than `txn_max_len`. Equal lengths do not set it.
- R5: A `txn_err` pulse sets status bit 1. When `txn_ioc` is high with it, status bits 1 and 0 are set in the same cycle.
- R6: `irq` is high while any of status bits 0..2 is set together with the enable bit at the same position. A source whose enable bit is clear still sets its status bit but does not drive `irq`.
- R7: While status bit 4 is set, `irq` is high whatever the enable register holds.
- R8: Enable bits 4..0 are read/write. Enable bits 15..5 read as 0 after any write.
- R9: `irq` is a level. It goes low in the cycle after the write that clears the last enabled active status bit, and not before.
- R10: When a hardware set and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R11: Status bit 5 reads as the inverse of `run_en`, one cycle late, and cannot be written. Status bits 3 and 15..6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 status, 1 enable |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| run_en | input | 1 | Controller running (command run/stop) |
| gsusp | input | 1 | Global suspend flag from the command register |
| txn_done | input | 1 | Transaction completed pulse |
| txn_ioc | input | 1 | Descriptor interrupt-on-complete flag |
| txn_spd_en | input | 1 | Descriptor short-packet detection enable |
| txn_act_len | input | LEN_W | Actual transferred length |
| txn_max_len | input | LEN_W | Maximum length of the descriptor |
| txn_err | input | 1 | Transaction error pulse |
| resume_sig | input | 1 | Resume signalling seen from a device |
| hc_proc_err | input | 1 | Host controller processor error pulse |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions assume that the descriptor attributes (`txn_ioc`, `txn_spd_en` and both lengths) are valid in every cycle that carries a `txn_done` or `txn_err` pulse. They also assume that all inputs are quiet and `run_en` is low while reset is held, because several checks compare against the inputs one cycle back. The stimulus holds every event line low during reset. It changes inputs only on falling edges and raises each event for exactly one cycle. It pairs a clear with a set on the same bit only in the one sequence meant to exercise that collision.

// File: rtl/uhc_irq_pkg.sv
package uhc_irq_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned BIT_XFER  = 0;
  localparam int unsigned BIT_ERR   = 1;
  localparam int unsigned BIT_RSM   = 2;
  localparam int unsigned BIT_FATAL = 4;
  localparam int unsigned BIT_HALT  = 5;

  // Bits cleared by writing one.
  localparam logic [REG_W-1:0] W1C_MASK = 16'h0017;
  // Bits held in the enable register.
  localparam logic [REG_W-1:0] IEN_MASK = 16'h001F;
  // Status bits that an enable bit can gate.
  localparam logic [REG_W-1:0] GATE_MASK = 16'h0007;
  localparam logic [REG_W-1:0] STS_RST  = 16'h0020;

  // Interrupt level from status and enable contents.
  function automatic logic irq_level(input logic [REG_W-1:0] sts,
                                     input logic [REG_W-1:0] ien);
    return (|(sts & ien & GATE_MASK)) | sts[BIT_FATAL];
  endfunction
endpackage

// File: rtl/uhc_evt_decode.sv
module uhc_evt_decode
  import uhc_irq_pkg::*;
#(
  parameter int unsigned LEN_W = 11
) (
  input  logic             done_i,
  input  logic             ioc_i,
  input  logic             spd_en_i,
  input  logic [LEN_W-1:0] act_len_i,
  input  logic [LEN_W-1:0] max_len_i,
  input  logic             err_i,
  input  logic             resume_i,
  input  logic             gsusp_i,
  input  logic             fatal_i,
  output logic [REG_W-1:0] set_vec_o
);
  // A packet is short when fewer bytes arrived than the descriptor allows.
  function automatic logic is_short(input logic [LEN_W-1:0] act,
                                    input logic [LEN_W-1:0] lim);
    return act < lim;
  endfunction

  logic ev_ioc_hit;
  logic ev_short_hit;
  logic ev_rsm_hit;

  assign ev_ioc_hit   = (done_i | err_i) & ioc_i;
  assign ev_short_hit = done_i & spd_en_i & is_short(act_len_i, max_len_i);
  assign ev_rsm_hit   = resume_i & gsusp_i;

  always_comb begin
    set_vec_o            = '0;
    set_vec_o[BIT_XFER]  = ev_ioc_hit | ev_short_hit;
    set_vec_o[BIT_ERR]   = err_i;
    set_vec_o[BIT_RSM]   = ev_rsm_hit;
    set_vec_o[BIT_FATAL] = fatal_i;
  end
endmodule

// File: rtl/uhc_sts_reg.sv
module uhc_sts_reg
  import uhc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec_i,
  input  logic             clr_stb_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             run_i,
  output logic [REG_W-1:0] sts_o
);
  logic unused_sts_in;
  assign unused_sts_in = ^{set_vec_i & ~W1C_MASK, wr_data_i & ~W1C_MASK};

  for (genvar b = 0; b < int'(REG_W); b++) begin : g_bit
    if (W1C_MASK[b]) begin : g_w1c
      logic q;
      logic clr_hit;
      assign clr_hit = clr_stb_i & wr_data_i[b];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            q <= STS_RST[b];
        else if (set_vec_i[b]) q <= 1'b1;
        else if (clr_hit)      q <= 1'b0;
      end
      assign sts_o[b] = q;

      p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec_i[b] |=> sts_o[b]);
      p_w1c_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !set_vec_i[b]) |=> !sts_o[b]);
      p_w1c_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_hit && !set_vec_i[b]) |=> $stable(sts_o[b]));
    end else if (b == int'(BIT_HALT)) begin : g_halt
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= STS_RST[b];
        else        q <= ~run_i;
      end
      assign sts_o[b] = q;

      p_halt_track_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sts_o[b] == !$past(run_i)));
    end else begin : g_rsvd
      assign sts_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/uhc_ien_reg.sv
module uhc_ien_reg
  import uhc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] ien_o
);
  logic unused_ien_in;
  assign unused_ien_in = ^(wr_data_i & ~IEN_MASK);

  for (genvar b = 0; b < int'(REG_W); b++) begin : g_bit
    if (IEN_MASK[b]) begin : g_rw
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= 1'b0;
        else if (wr_stb_i) q <= wr_data_i[b];
      end
      assign ien_o[b] = q;
    end else begin : g_rsvd
      assign ien_o[b] = 1'b0;
    end
  end

  p_ien_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_i |=> (ien_o == ($past(wr_data_i) & IEN_MASK)));
endmodule

// File: rtl/uhc_irq_status.sv
module uhc_irq_status
  import uhc_irq_pkg::*;
#(
  parameter int unsigned LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_addr,
  input  logic             reg_wr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic             run_en,
  input  logic             gsusp,
  input  logic             txn_done,
  input  logic             txn_ioc,
  input  logic             txn_spd_en,
  input  logic [LEN_W-1:0] txn_act_len,
  input  logic [LEN_W-1:0] txn_max_len,
  input  logic             txn_err,
  input  logic             resume_sig,
  input  logic             hc_proc_err,
  output logic             irq
);
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] sts_q;
  logic [REG_W-1:0] ien_q;
  logic             sts_wr;
  logic             ien_wr;

  assign sts_wr = reg_wr & ~reg_addr;
  assign ien_wr = reg_wr &  reg_addr;

  uhc_evt_decode #(.LEN_W(LEN_W)) u_decode (
    .done_i    (txn_done),
    .ioc_i     (txn_ioc),
    .spd_en_i  (txn_spd_en),
    .act_len_i (txn_act_len),
    .max_len_i (txn_max_len),
    .err_i     (txn_err),
    .resume_i  (resume_sig),
    .gsusp_i   (gsusp),
    .fatal_i   (hc_proc_err),
    .set_vec_o (set_vec)
  );

  uhc_sts_reg u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec_i (set_vec),
    .clr_stb_i (sts_wr),
    .wr_data_i (reg_wdata),
    .run_i     (run_en),
    .sts_o     (sts_q)
  );

  uhc_ien_reg u_ien (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb_i  (ien_wr),
    .wr_data_i (reg_wdata),
    .ien_o     (ien_q)
  );

  assign irq       = irq_level(sts_q, ien_q);
  assign reg_rdata = reg_addr ? ien_q : sts_q;

  p_rsm_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[BIT_RSM]) |-> $past(resume_sig && gsusp));
  p_dual_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_err && txn_ioc) |=> (sts_q[BIT_ERR] && sts_q[BIT_XFER]));
  p_fatal_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[BIT_FATAL] |-> irq);
  p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_wr));
endmodule

// File: tb/test_uhc_irq_status.sv
module test_uhc_irq_status;
  localparam int LW = 11;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_addr = 1'b0, reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic run_en = 1'b0, gsusp = 1'b0;
  logic txn_done = 1'b0, txn_ioc = 1'b0, txn_spd_en = 1'b0, txn_err = 1'b0;
  logic [LW-1:0] txn_act_len = '0, txn_max_len = '0;
  logic resume_sig = 1'b0, hc_proc_err = 1'b0;
  logic irq;

  always #4 clk = ~clk;  // 125 MHz

  uhc_irq_status #(.LEN_W(LW)) i_uhc_irq_status (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .run_en(run_en),
    .gsusp(gsusp), .txn_done(txn_done), .txn_ioc(txn_ioc),
    .txn_spd_en(txn_spd_en), .txn_act_len(txn_act_len),
    .txn_max_len(txn_max_len), .txn_err(txn_err), .resume_sig(resume_sig),
    .hc_proc_err(hc_proc_err), .irq(irq));

  typedef struct {
    bit          is_irq;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  event  mon_ev;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done_flag = 1'b0;

  // Monitor: pops the expected item and compares it with the outputs.
  initial begin
    forever begin
      @(mon_ev);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {15'd0, irq} : reg_rdata;
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual 0x%04h expected 0x%04h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push_rd(input logic a, input logic [15:0] e, input string t);
    item_t it;
    reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = t;
    sb_q.push_back(it);
    -> mon_ev;
    #2;
  endtask

  task automatic push_irq(input logic e, input string t);
    item_t it;
    it.is_irq = 1'b1; it.exp = {15'd0, e}; it.tag = t;
    sb_q.push_back(it);
    -> mon_ev;
    #2;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic txn(input logic dn, input logic ioc, input logic spd,
                     input int act, input int mx, input logic er);
    @(negedge clk);
    txn_done = dn; txn_ioc = ioc; txn_spd_en = spd; txn_err = er;
    txn_act_len = LW'(act); txn_max_len = LW'(mx);
    @(negedge clk);
    txn_done = 0; txn_ioc = 0; txn_spd_en = 0; txn_err = 0;
  endtask

  task automatic pulse_rsm(input logic susp);
    @(negedge clk);
    gsusp = susp; resume_sig = 1'b1;
    @(negedge clk);
    resume_sig = 1'b0; gsusp = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    push_rd(0, 16'h0020, "R1 status reset");
    push_rd(1, 16'h0000, "R1 enable reset");
    push_irq(0, "R1 irq reset");
    rst_n = 1'b1;
    @(negedge clk);
    push_rd(0, 16'h0020, "R11 halted while stopped");
    run_en = 1'b1;
    @(negedge clk);
    push_rd(0, 16'h0000, "R11 halt clears when running");
    wr(0, 16'hFFFF);
    push_rd(0, 16'h0000, "R11 reserved/halt not writable");
    // R8
    wr(1, 16'hFFFF);
    push_rd(1, 16'h001F, "R8 enable upper bits read 0");
    wr(1, 16'h0000);
    push_rd(1, 16'h0000, "R8 enable cleared");
    // R6 / R4 / R2 / R9
    txn(1, 1, 0, 0, 0, 0);
    push_rd(0, 16'h0001, "R4 done with ioc");
    push_irq(0, "R6 disabled source no irq");
    wr(1, 16'h0001);
    push_irq(1, "R6 enabled source drives irq");
    wr(0, 16'h0000);
    push_rd(0, 16'h0001, "R2 write zero keeps bit");
    wr(0, 16'h0001);
    push_rd(0, 16'h0000, "R2 write one clears bit");
    push_irq(0, "R9 irq low after clear");
    // R4 short packet
    txn(1, 0, 1, 5, 8, 0);
    push_rd(0, 16'h0001, "R4 short packet");
    wr(0, 16'h0001);
    txn(1, 0, 1, 8, 8, 0);
    push_rd(0, 16'h0000, "R4 equal length not short");
    txn(1, 0, 0, 5, 8, 0);
    push_rd(0, 16'h0000, "R4 detection disabled");
    // R5
    txn(0, 1, 0, 0, 0, 1);
    push_rd(0, 16'h0003, "R5 error with ioc");
    wr(0, 16'h0003);
    txn(0, 0, 0, 0, 0, 1);
    push_rd(0, 16'h0002, "R5 error without ioc");
    wr(0, 16'h0002);
    // R3
    pulse_rsm(0);
    push_rd(0, 16'h0000, "R3 resume ignored when awake");
    pulse_rsm(1);
    push_rd(0, 16'h0004, "R3 resume in suspend");
    wr(0, 16'h0004);
    // R7
    wr(1, 16'h0000);
    @(negedge clk);
    hc_proc_err = 1'b1;
    @(negedge clk);
    hc_proc_err = 1'b0;
    push_rd(0, 16'h0010, "R7 fatal status");
    push_irq(1, "R7 fatal irq unmaskable");
    wr(0, 16'h0010);
    push_irq(0, "R7 irq low after fatal cleared");
    // R10 set wins over clear
    @(negedge clk);
    reg_addr = 0; reg_wdata = 16'h0001; reg_wr = 1'b1;
    txn_done = 1'b1; txn_ioc = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; txn_done = 1'b0; txn_ioc = 1'b0;
    push_rd(0, 16'h0001, "R10 set wins");
    // R9 drop only after last enabled bit clears
    wr(1, 16'h0003);
    txn(0, 0, 0, 0, 0, 1);
    push_rd(0, 16'h0003, "R9 two bits active");
    wr(0, 16'h0001);
    push_irq(1, "R9 irq held by remaining bit");
    wr(0, 16'h0002);
    push_irq(0, "R9 irq drops after last clear");
    done_flag = 1'b1;
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule